// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and turns single-cycle event pulses from peripheral sources into one vectored request. Each event sets a sticky pending flag. The flags are masked by per-source enables and by one global enable bit. The lowest-numbered unmasked source is offered to the core, together with a program address for its handler.

The core answers with an acknowledge. That clock edge clears the serviced flag and drops the global enable, so the handler runs without being interrupted. A return pulse from the core sets the global enable again. Software can also set the global enable inside a handler to allow nesting. It uses a small write port to load enables, to clear flags by writing ones, and to set the global enable and the vector-table select bit.

A two-state machine drives the handshake:
- `ST_IDLE`: no request is offered. It moves to `ST_ARMED` (transition *arm*) in the cycle after the arbiter finds a winner.
- `ST_ARMED`: the winner's index is held and the request is raised. It returns to `ST_IDLE` on an acknowledge (transition *take*). It also returns to `ST_IDLE` when the held source stops being the arbiter's winner (transition *retract*), which happens after masking, clearing, or a higher-priority arrival.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source can produce a request only while its enable bit is 1 and the global enable is 1. Enables are loaded by a write with `wr_sel`=0, where bit i of the data is source i.
- R2: When several sources are unmasked and pending, the request carries the vector of the lowest-numbered one.
- R3: An acknowledge given while `irq_req` is high clears the global enable at that clock edge.
- R4: If software sets the global enable again after an acknowledge, any enabled pending source raises a new request two cycles after the write.
- R5: A pulse on `irq_ret` sets the global enable at the next edge, unless an acknowledge is taken in the same cycle.
- R6: An acknowledge clears the pending flag of the source being serviced.
- R7: A write with `wr_sel`=1 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: An event sets its flag even while the source or the global enable is off. The flag stays set until it is serviced or cleared. Flags unmasked together are serviced lowest index first.
- R9: The vector for source i is base + 2·(i+1), where slot 0 is reserved for reset. The base is 0 when control bit 1 is 0 and `ALT_BASE` when it is 1. Control is written with `wr_sel`=2; bit 0 of the data is the global enable.
- R10: If an event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R11: After reset, all flags, all enables, the global enable and the vector select are 0, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NUM_SRC | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 enables, 1 flag clear, 2 control |
| wr_data | input | NUM_SRC | Write data |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | ADDR_W | Handler address of the offered source |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core executed return-from-interrupt |
| gie | output | 1 | Global enable state |
| pend_flags | output | NUM_SRC | Pending flags |

## Verification
The arbiter is swept over all 255 non-empty pending patterns with every source enabled, and over all 256 enable masks with every flag set. The first sweep shows the priority order; the second shows the per-source gating, including the no-request case. In the first sweep the flags are loaded while the global enable is off, then each acknowledge is checked to clear exactly the winning flag. Directed sequences cover nesting, return, the alternate base, selective clearing, and an event colliding with a clear in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } irq_state_e;

    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_CLEAR  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] wr_mask,
    input  logic               svc_clr,
    input  logic [IDX_W-1:0]   svc_idx,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] flags_d;

    always_comb begin
        clr = wr_mask;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (svc_clr && (svc_idx == IDX_W'(i))) clr[i] = 1'b1;
        end
        flags_d = (flags_q & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assert_event_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_mask & ~evt) != '0) |=> ((flags_q & $past(wr_mask & ~evt)) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] enables,
    input  logic               glob_en,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] live;

    always_comb begin
        live      = glob_en ? (flags & enables) : '0;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] ALT_BASE = 16'h1E00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_event,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic               irq_req,
    output logic [ADDR_W-1:0]  irq_vector,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               gie,
    output logic [NUM_SRC-1:0] pend_flags
);
    localparam int IDX_W = $clog2(NUM_SRC + 1);

    irq_state_e         state_q, state_d;
    logic [IDX_W-1:0]   held_q;
    logic [NUM_SRC-1:0] en_q;
    logic               gie_q, vsel_q;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               take;
    logic [NUM_SRC-1:0] clr_mask;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  slot;

    assign clr_mask = (wr_en && wr_sel == SEL_CLEAR) ? wr_data : '0;
    assign take     = irq_req && irq_ack;

    irq_flag_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (src_event),
        .wr_mask (clr_mask),
        .svc_clr (take),
        .svc_idx (held_q),
        .flags_q (pend_flags)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .flags     (pend_flags),
        .enables   (en_q),
        .glob_en   (gie_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // control registers: acknowledge beats return, return beats a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            gie_q  <= 1'b0;
            vsel_q <= 1'b0;
        end else begin
            if (wr_en && wr_sel == SEL_ENABLE) en_q <= wr_data;
            if (wr_en && wr_sel == SEL_CTRL) vsel_q <= wr_data[1];
            if (take)                         gie_q <= 1'b0;
            else if (irq_ret)                 gie_q <= 1'b1;
            else if (wr_en && wr_sel == SEL_CTRL) gie_q <= wr_data[0];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && win_valid) held_q <= win_idx;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_valid) state_d = ST_ARMED;
            ST_ARMED: begin
                if (take) state_d = ST_IDLE;
                else if (!win_valid || win_idx != held_q) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        base       = vsel_q ? ADDR_W'(ALT_BASE) : '0;
        slot       = ADDR_W'(held_q) + ADDR_W'(1);
        irq_vector = base + (slot << 1);
        irq_req    = 1'b0;
        unique case (state_q)
            ST_IDLE:  irq_req = 1'b0;
            ST_ARMED: irq_req = win_valid && (win_idx == held_q);
            default:  irq_req = 1'b0;
        endcase
    end

    assign gie = gie_q;

    assert_req_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gie && pend_flags[held_q] && en_q[held_q]));

    assert_take_drops_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie);

    assert_ret_sets_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !take) |=> gie);

    assert_take_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !src_event[held_q]) |=> !pend_flags[$past(held_q)]);

    assert_vector_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !irq_vector[0]);
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
    localparam int N   = 8;
    localparam int AW  = 16;
    localparam int ALT = 16'h1E00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_event = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic          irq_ack = 1'b0;
    logic          irq_ret = 1'b0;
    logic          irq_req;
    logic [AW-1:0] irq_vector;
    logic          gie;
    logic [N-1:0]  pend_flags;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_event(src_event), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .gie(gie), .pend_flags(pend_flags)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [N-1:0] e);
        src_event = e;
        @(negedge clk);
        src_event = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int vec(input int base, input int i);
        return base + 2 * (i + 1);
    endfunction

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 flags", int'(pend_flags), 0);
        check("R11 gie", int'(gie), 0);
        check("R11 req", int'(irq_req), 0);
        pulse(8'hFF);
        idle(2);
        check("R11 enables zero, no req", int'(irq_req), 0);
        wr(2'd1, 8'hFF);

        // sweep pending patterns with all enabled
        wr(2'd0, 8'hFF);
        for (int p = 1; p < 256; p++) begin
            int w;
            w = lowest(p[N-1:0]);
            pulse(p[N-1:0]);
            idle(2);
            check("R8 masked flag kept", int'(pend_flags), p);
            check("R8 no req while gie off", int'(irq_req), 0);
            wr(2'd2, 8'h01);
            idle(1);
            check("R2 req", int'(irq_req), 1);
            check("R2 vector", int'(irq_vector), vec(0, w));
            ack();
            check("R3 gie cleared", int'(gie), 0);
            check("R6 flag cleared", int'(pend_flags), p & ~(1 << w));
            wr(2'd1, 8'hFF);
        end

        // sweep enable masks with all flags set
        pulse(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(2'd0, m[N-1:0]);
            wr(2'd2, 8'h01);
            idle(1);
            check("R1 req gating", int'(irq_req), (m != 0) ? 1 : 0);
            if (m != 0) check("R1 vector", int'(irq_vector), vec(0, lowest(m[N-1:0])));
            wr(2'd2, 8'h00);
            idle(2);
            check("R1 gie off drops req", int'(irq_req), 0);
        end

        // R8 priority order on joint unmask, R4 nesting, R5 return
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        pulse(8'b0010_0100);
        wr(2'd2, 8'h01);
        idle(1);
        check("R8 first served", int'(irq_vector), vec(0, 2));
        ack();
        check("R3 gie after ack", int'(gie), 0);
        idle(2);
        check("R3 blocked in handler", int'(irq_req), 0);
        wr(2'd2, 8'h01);
        idle(1);
        check("R4 nested req", int'(irq_req), 1);
        check("R8 second served", int'(irq_vector), vec(0, 5));
        ack();
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
        check("R5 ret sets gie", int'(gie), 1);

        // R9 alternate base
        wr(2'd2, 8'h03);
        pulse(8'h80);
        idle(2);
        check("R9 alt base vector", int'(irq_vector), vec(ALT, 7));
        ack();
        check("R9 ack at alt base", int'(pend_flags), 0);

        // R7 selective clear, R10 collision
        wr(2'd2, 8'h00);
        pulse(8'hF0);
        wr(2'd1, 8'h30);
        check("R7 partial clear", int'(pend_flags), 8'hC0);
        src_event = 8'h40;
        wr(2'd1, 8'h40);
        src_event = '0;
        check("R10 event beats clear", int'(pend_flags), 8'hC0);
        wr(2'd1, 8'h00);
        check("R7 zero write no effect", int'(pend_flags), 8'hC0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule